// File: doc/BRIEF.md
# Packed Subword SIMD ALU

This block is a registered integer ALU on a 64-bit word that the operation itself partitions. The word holds four 16-bit elements, two 32-bit elements or one 64-bit element, and one shared adder and one shared shifter are cut at the matching boundaries. The block implements add, subtract, AND, OR, shift left and shift right. Each element is read as signed or unsigned. Arithmetic results either wrap, with overflow flagged, or clamp to the element's range.

Either operand can be a scalar. The low element of that operand is then copied into every element position. A per-element mask decides which elements are written back. The block registers everything, so the result, the per-16-bit-lane write enables and the overflow flags appear one cycle after a valid input.

Top module: `simd_lane_alu`

## Requirements
- R1: `width_i` selects the element width: 0 gives four 16-bit elements, 1 gives two 32-bit elements, and 2 or 3 gives one 64-bit element. Element e occupies bits [e*W +: W]. Carries and shifted bits stay inside their own element.
- R2: `form_i` selects the operand form. 0 uses both operands as vectors. 1 copies the low element of `opb_i` into every element. 2 copies the low element of `opa_i` into every element. 3 behaves as 0.
- R3: `op_i` 0 adds and 1 subtracts (a minus b), wrapping modulo 2^W when `sat_i`=0. Overflow is the signed range being exceeded when `sgn_i`=1, carry-out on an unsigned add, and borrow on an unsigned subtract.
- R4: When `sat_i`=1, an overflowing element clamps. Signed results clamp to 0x7FF…F on positive overflow and to 0x800…0 on negative overflow. Unsigned results clamp to all-ones on add and to zero on subtract. The overflow flag is still reported.
- R5: `op_i` 2 gives the bitwise AND and 3 gives the bitwise OR. Neither ever reports overflow. Codes 6 and 7 give a zero result and no overflow.
- R6: `op_i` 4 shifts left and 5 shifts right. The amount is the low log2(W) bits of the element of the second operand. A right shift is arithmetic when `sgn_i`=1 and logical otherwise.
- R7: `wen_o` holds one bit per 16-bit lane. With `mask_en_i`=0, all four bits are 1. With `mask_en_i`=1, every lane of element e takes `mask_i[e]`.
- R8: `ovf_o` holds one bit per 16-bit lane. Only the top lane of each element can be set, and only when that lane's `wen_o` bit is 1.
- R9: The outputs follow a valid input after exactly one clock. When the previous cycle had no valid input, and during reset, `valid_o`, `wen_o` and `ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code |
| width_i | input | 2 | Element width select |
| form_i | input | 2 | Operand form select |
| sgn_i | input | 1 | Signed interpretation |
| sat_i | input | 1 | Saturate (1) or wrap (0) |
| mask_en_i | input | 1 | Apply the element mask |
| mask_i | input | 4 | Per-element write flags |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| valid_o | output | 1 | Result present |
| result_o | output | 64 | Packed result |
| wen_o | output | 4 | Write enable per 16-bit lane |
| ovf_o | output | 4 | Overflow per 16-bit lane |

## Verification
The checker checks several properties on every cycle:
- the one-cycle valid timing;
- that write enables and overflow flags are silent without a valid result;
- that overflow never appears on a lane that is not written, or on a lane below the top of a 32-bit or 64-bit element;
- that unmasked operations enable every lane;
- that logic operations never flag overflow.

The bench scenarios are needed for the values themselves. They cover carries that stop at element edges, the clamp values for each signedness, operand replication, and shift amounts that are truncated to the element width.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int NLANE = 4;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_SHL = 3'd4;
  localparam logic [2:0] OP_SHR = 3'd5;

  localparam logic [1:0] EW_16 = 2'd0;
  localparam logic [1:0] EW_32 = 2'd1;

  localparam logic [1:0] FORM_VS = 2'd1;
  localparam logic [1:0] FORM_SV = 2'd2;

  // lanes that open an element
  function automatic logic [NLANE-1:0] start_lanes(input logic [1:0] w);
    case (w)
      EW_16:   return 4'b1111;
      EW_32:   return 4'b0101;
      default: return 4'b0001;
    endcase
  endfunction

  // lanes that close an element
  function automatic logic [NLANE-1:0] top_lanes(input logic [1:0] w);
    case (w)
      EW_16:   return 4'b1111;
      EW_32:   return 4'b1010;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic int top_of(input int k, input logic [1:0] w);
    case (w)
      EW_16:   return k;
      EW_32:   return k | 1;
      default: return NLANE - 1;
    endcase
  endfunction

  function automatic int elem_of(input int k, input logic [1:0] w);
    case (w)
      EW_16:   return k;
      EW_32:   return k >> 1;
      default: return 0;
    endcase
  endfunction

  // index mask selecting the source lane of a replicated scalar
  function automatic int rep_mask(input logic [1:0] w);
    case (w)
      EW_16:   return 0;
      EW_32:   return 1;
      default: return NLANE - 1;
    endcase
  endfunction
endpackage

// File: rtl/simd_operand_sel.sv
module simd_operand_sel
  import simd_alu_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int DATA_W = LANE_W * NLANE
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        form_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic [DATA_W-1:0] a_rep, b_rep;

  always_comb begin
    for (int k = 0; k < NLANE; k++) begin
      a_rep[k*LANE_W +: LANE_W] = a_i[(k & rep_mask(width_i))*LANE_W +: LANE_W];
      b_rep[k*LANE_W +: LANE_W] = b_i[(k & rep_mask(width_i))*LANE_W +: LANE_W];
    end
  end

  assign a_o = (form_i == FORM_SV) ? a_rep : a_i;
  assign b_o = (form_i == FORM_VS) ? b_rep : b_i;
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_alu_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int DATA_W = LANE_W * NLANE
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              sgn_i,
  input  logic              sat_i,
  input  logic [1:0]        width_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NLANE-1:0]  ovf_o
);
  logic [NLANE-1:0]  st, tp, cout, ov, a_msb;
  logic [DATA_W-1:0] sum;

  assign st = start_lanes(width_i);
  assign tp = top_lanes(width_i);

  // lane-sliced ripple; chain cut at element starts
  always_comb begin
    logic              carry;
    logic [LANE_W-1:0] bx;
    logic [LANE_W:0]   t;
    carry = 1'b0;
    for (int k = 0; k < NLANE; k++) begin
      bx = sub_i ? ~b_i[k*LANE_W +: LANE_W] : b_i[k*LANE_W +: LANE_W];
      t  = {1'b0, a_i[k*LANE_W +: LANE_W]} + {1'b0, bx}
         + {{LANE_W{1'b0}}, (st[k] ? sub_i : carry)};
      carry   = t[LANE_W];
      cout[k] = t[LANE_W];
      sum[k*LANE_W +: LANE_W] = t[LANE_W-1:0];
      a_msb[k] = a_i[k*LANE_W + LANE_W - 1];
      if (sgn_i)
        ov[k] = (a_msb[k] == bx[LANE_W-1]) && (t[LANE_W-1] != a_msb[k]);
      else
        ov[k] = sub_i ? ~t[LANE_W] : t[LANE_W];
    end
  end

  always_comb begin
    int t_l;
    for (int k = 0; k < NLANE; k++) begin
      t_l = top_of(k, width_i);
      if (sat_i && ov[t_l]) begin
        if (sgn_i) begin
          if (!a_msb[t_l])
            res_o[k*LANE_W +: LANE_W] = (k == t_l) ? {1'b0, {(LANE_W-1){1'b1}}} : {LANE_W{1'b1}};
          else
            res_o[k*LANE_W +: LANE_W] = (k == t_l) ? {1'b1, {(LANE_W-1){1'b0}}} : {LANE_W{1'b0}};
        end else begin
          res_o[k*LANE_W +: LANE_W] = sub_i ? {LANE_W{1'b0}} : {LANE_W{1'b1}};
        end
      end else begin
        res_o[k*LANE_W +: LANE_W] = sum[k*LANE_W +: LANE_W];
      end
    end
  end

  assign ovf_o = ov & tp;
endmodule

// File: rtl/simd_shifter.sv
module simd_shifter
  import simd_alu_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int DATA_W = LANE_W * NLANE,
  localparam int NMODE  = 3
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              left_i,
  input  logic              arith_i,
  input  logic [1:0]        width_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] mode_res [NMODE];

  for (genvar g = 0; g < NMODE; g++) begin : g_mode
    localparam int EW = LANE_W << g;
    localparam int NE = NLANE >> g;
    localparam int SH = $clog2(EW);
    logic [DATA_W-1:0] r;
    for (genvar e = 0; e < NE; e++) begin : g_el
      logic [EW-1:0] src, shl, srl, sra;
      logic [SH-1:0] amt;
      assign src = a_i[e*EW +: EW];
      assign amt = b_i[e*EW +: SH];
      assign shl = src << amt;
      assign srl = src >> amt;
      assign sra = $signed(src) >>> amt;
      assign r[e*EW +: EW] = left_i ? shl : (arith_i ? sra : srl);
    end
    assign mode_res[g] = r;
  end

  always_comb begin
    case (width_i)
      EW_16:   res_o = mode_res[0];
      EW_32:   res_o = mode_res[1];
      default: res_o = mode_res[2];
    endcase
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int DATA_W = LANE_W * NLANE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        form_i,
  input  logic              sgn_i,
  input  logic              sat_i,
  input  logic              mask_en_i,
  input  logic [NLANE-1:0]  mask_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [NLANE-1:0]  wen_o,
  output logic [NLANE-1:0]  ovf_o
);
  logic [DATA_W-1:0] a_s, b_s, as_res, sh_res, res_d;
  logic [NLANE-1:0]  as_ovf, wen_d, ovf_d;
  logic              is_arith;

  simd_operand_sel #(.LANE_W(LANE_W)) u_sel (
    .a_i(opa_i), .b_i(opb_i), .width_i(width_i), .form_i(form_i),
    .a_o(a_s), .b_o(b_s)
  );

  simd_addsub #(.LANE_W(LANE_W)) u_addsub (
    .a_i(a_s), .b_i(b_s), .sub_i(op_i == OP_SUB), .sgn_i(sgn_i),
    .sat_i(sat_i), .width_i(width_i), .res_o(as_res), .ovf_o(as_ovf)
  );

  simd_shifter #(.LANE_W(LANE_W)) u_shift (
    .a_i(a_s), .b_i(b_s), .left_i(op_i == OP_SHL), .arith_i(sgn_i),
    .width_i(width_i), .res_o(sh_res)
  );

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB: res_d = as_res;
      OP_AND:         res_d = a_s & b_s;
      OP_OR:          res_d = a_s | b_s;
      OP_SHL, OP_SHR: res_d = sh_res;
      default:        res_d = '0;
    endcase
  end

  always_comb begin
    for (int k = 0; k < NLANE; k++)
      wen_d[k] = mask_en_i ? mask_i[elem_of(k, width_i)] : 1'b1;
  end

  assign ovf_d = is_arith ? (as_ovf & wen_d) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      wen_o    <= '0;
      ovf_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
      wen_o   <= valid_i ? wen_d : '0;
      ovf_o   <= valid_i ? ovf_d : '0;
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic [1:0]  width_i,
  input logic        mask_en_i,
  input logic        valid_o,
  input logic [3:0]  wen_o,
  input logic [3:0]  ovf_o
);
  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && wen_o == 4'h0 && ovf_o == 4'h0));
  // R8
  ovf_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o & ~wen_o) == 4'h0);
  // R8
  ovf_top32_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && width_i == 2'd1) |=> (ovf_o[0] == 1'b0 && ovf_o[2] == 1'b0));
  // R8
  ovf_top64_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && width_i[1]) |=> (ovf_o[2:0] == 3'b000));
  // R7
  unmasked_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mask_en_i) |=> (wen_o == 4'hF));
  // R5
  logic_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd2 || op_i == 3'd3)) |=> (ovf_o == 4'h0));
endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .width_i(width_i), .mask_en_i(mask_en_i), .valid_o(valid_o),
  .wen_o(wen_o), .ovf_o(ovf_o)
);

// File: tb/simd_lane_alu_bench.sv
`timescale 1ns/1ps
module simd_lane_alu_bench;
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  w;
    logic [1:0]  form;
    logic        sat;
    logic        sgn;
    logic        men;
    logic [3:0]  mask;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic [3:0]  wen;
    logic [3:0]  ovf;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    // R1 R3: unsigned wrap, 16-bit, carry stops at lane edge
    '{3'd0,2'd0,2'd0,1'b0,1'b0,1'b0,4'h0,64'h0001_0002_FFFF_7FFF,64'h0001_0001_0001_0001,64'h0002_0003_0000_8000,4'hF,4'h2},
    // R3: signed wrap
    '{3'd0,2'd0,2'd0,1'b0,1'b1,1'b0,4'h0,64'h0001_0002_FFFF_7FFF,64'h0001_0001_0001_0001,64'h0002_0003_0000_8000,4'hF,4'h1},
    // R4: signed clamp
    '{3'd0,2'd0,2'd0,1'b1,1'b1,1'b0,4'h0,64'h0001_0002_FFFF_7FFF,64'h0001_0001_0001_0001,64'h0002_0003_0000_7FFF,4'hF,4'h1},
    // R4: unsigned add clamp
    '{3'd0,2'd0,2'd0,1'b1,1'b0,1'b0,4'h0,64'h0001_0002_FFFF_7FFF,64'h0001_0001_0001_0001,64'h0002_0003_FFFF_8000,4'hF,4'h2},
    // R4: unsigned sub clamp, 32-bit
    '{3'd1,2'd1,2'd0,1'b1,1'b0,1'b0,4'h0,64'h00000005_00000010,64'h00000006_00000001,64'h00000000_0000000F,4'hF,4'h8},
    // R4: signed sub negative clamp, 32-bit
    '{3'd1,2'd1,2'd0,1'b1,1'b1,1'b0,4'h0,64'h80000000_00000003,64'h00000001_00000005,64'h80000000_FFFFFFFE,4'hF,4'h8},
    // R1 R3: 64-bit signed wrap
    '{3'd0,2'd2,2'd0,1'b0,1'b1,1'b0,4'h0,64'h7FFFFFFF_FFFFFFFF,64'h1,64'h80000000_00000000,4'hF,4'h8},
    // R4: 64-bit unsigned clamp
    '{3'd0,2'd2,2'd0,1'b1,1'b0,1'b0,4'h0,64'hFFFFFFFF_FFFFFFFF,64'h1,64'hFFFFFFFF_FFFFFFFF,4'hF,4'h8},
    // R2 R5: AND, scalar b replicated
    '{3'd2,2'd0,2'd1,1'b1,1'b0,1'b0,4'h0,64'hF0F0_FFFF_1234_00FF,64'hAAAA_BBBB_CCCC_0F0F,64'h0000_0F0F_0204_000F,4'hF,4'h0},
    // R2 R5: OR, scalar a replicated
    '{3'd3,2'd1,2'd2,1'b0,1'b0,1'b0,4'h0,64'h12345678_0000FF00,64'h00FF0000_0000000F,64'h00FFFF00_0000FF0F,4'hF,4'h0},
    // R6: shift left, amount truncated
    '{3'd4,2'd0,2'd0,1'b0,1'b0,1'b0,4'h0,64'h8001_0001_0001_FFFF,64'h0001_0004_0010_000F,64'h0002_0010_0001_8000,4'hF,4'h0},
    // R6: arithmetic right
    '{3'd5,2'd0,2'd0,1'b0,1'b1,1'b0,4'h0,64'h8000_8000_7FFF_F00F,64'h0004_0004_0001_0004,64'hF800_F800_3FFF_FF00,4'hF,4'h0},
    // R6: logical right
    '{3'd5,2'd0,2'd0,1'b0,1'b0,1'b0,4'h0,64'h8000_8000_7FFF_F00F,64'h0004_0004_0001_0004,64'h0800_0800_3FFF_0F00,4'hF,4'h0},
    // R6 R1: 32-bit arithmetic right, 5-bit amount
    '{3'd5,2'd1,2'd0,1'b0,1'b1,1'b0,4'h0,64'h80000000_00000100,64'h0000001F_00000024,64'hFFFFFFFF_00000010,4'hF,4'h0},
    // R7: 32-bit mask, element 1 only
    '{3'd0,2'd1,2'd0,1'b0,1'b0,1'b1,4'h2,64'h00000001_00000001,64'h00000001_00000001,64'h00000002_00000002,4'hC,4'h0},
    // R7 R8: masked lane hides its overflow
    '{3'd0,2'd0,2'd0,1'b0,1'b0,1'b1,4'h5,64'h0000_0000_FFFF_0000,64'h0000_0000_0001_0000,64'h0000_0000_0000_0000,4'h5,4'h0},
    // R7: 64-bit uses mask bit 0 only
    '{3'd0,2'd2,2'd0,1'b0,1'b0,1'b1,4'hE,64'h0,64'h0,64'h0,4'h0,4'h0},
    // R2 R3: signed sub with scalar b
    '{3'd1,2'd0,2'd1,1'b0,1'b1,1'b0,4'h0,64'h0000_8000_0005_0003,64'h1234_5678_9ABC_0001,64'hFFFF_7FFF_0004_0002,4'hF,4'h4},
    // R1: carry crosses 16-bit edge inside 32-bit element
    '{3'd0,2'd1,2'd0,1'b0,1'b0,1'b0,4'h0,64'h0000FFFF_0000FFFF,64'h00000001_00000001,64'h00010000_00010000,4'hF,4'h0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  width_i = '0;
  logic [1:0]  form_i = '0;
  logic        sgn_i = 1'b0;
  logic        sat_i = 1'b0;
  logic        mask_en_i = 1'b0;
  logic [3:0]  mask_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [3:0]  wen_o;
  logic [3:0]  ovf_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  simd_lane_alu u_simd_lane_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .width_i(width_i), .form_i(form_i), .sgn_i(sgn_i), .sat_i(sat_i),
    .mask_en_i(mask_en_i), .mask_i(mask_i), .opa_i(opa_i), .opb_i(opb_i),
    .valid_o(valid_o), .result_o(result_o), .wen_o(wen_o), .ovf_o(ovf_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R9 act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: reset state
    check("R9 reset valid_o", {63'b0, valid_o}, 64'h0);
    check("R9 reset wen_o", {60'b0, wen_o}, 64'h0);
    check("R9 reset ovf_o", {60'b0, ovf_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      valid_i = 1'b1;
      op_i = VECS[i].op; width_i = VECS[i].w; form_i = VECS[i].form;
      sat_i = VECS[i].sat; sgn_i = VECS[i].sgn; mask_en_i = VECS[i].men;
      mask_i = VECS[i].mask; opa_i = VECS[i].a; opb_i = VECS[i].b;
      @(negedge clk_i);
      check($sformatf("vec %0d result R1-set", i), result_o, VECS[i].res);
      check($sformatf("vec %0d wen R7", i), {60'b0, wen_o}, {60'b0, VECS[i].wen});
      check($sformatf("vec %0d ovf R8", i), {60'b0, ovf_o}, {60'b0, VECS[i].ovf});
      check($sformatf("vec %0d valid R9", i), {63'b0, valid_o}, 64'h1);
    end

    // R9: idle cycle clears strobes, result held
    valid_i = 1'b0;
    opa_i = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk_i);
    check("R9 idle valid_o", {63'b0, valid_o}, 64'h0);
    check("R9 idle wen_o", {60'b0, wen_o}, 64'h0);
    check("R9 idle ovf_o", {60'b0, ovf_o}, 64'h0);

    // R5: undefined opcode gives zero
    valid_i = 1'b1; op_i = 3'd7; width_i = 2'd0; form_i = 2'd0;
    mask_en_i = 1'b0; opa_i = 64'h1234; opb_i = 64'h5678;
    @(negedge clk_i);
    check("R5 undefined op result", result_o, 64'h0);

    // R2: form 3 acts as vector-vector
    op_i = 3'd3; form_i = 2'd3; opa_i = 64'h0001_0000_0000_0000; opb_i = 64'h0000_0000_0000_0002;
    @(negedge clk_i);
    check("R2 form 3 result", result_o, 64'h0001_0000_0000_0002);

    // R1: width 3 acts as 64-bit
    op_i = 3'd0; form_i = 2'd0; width_i = 2'd3; sat_i = 1'b0; sgn_i = 1'b0;
    opa_i = 64'h0000_0000_0000_FFFF; opb_i = 64'h1;
    @(negedge clk_i);
    check("R1 width 3 result", result_o, 64'h0000_0000_0001_0000);
    valid_i = 1'b0;
    @(negedge clk_i);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule